// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects level-sensitive interrupt lines from peripherals and presents one interrupt output per CPU in a small multiprocessor. Software controls it through a simple register bus. A shared window holds the per-source enable, a routing word for each source that selects which CPUs may see it, and a read-only word giving the number of implemented sources. Each CPU has its own window with a per-source mask and an acknowledge register. The acknowledge register reports the source that CPU should service next.

Enables and masks are not changed by read-modify-write of bitmaps. Software writes a source number to a set register or a clear register. Source number 0 is reserved for the inter-processor doorbell summary, which comes from a separate block and takes priority over every other source. One source number belongs to a private timer per CPU. That timer bypasses the shared enable and the routing word and is gated only by the mask of the owning CPU. An acknowledge read has no side effect, so two CPUs that both have a source routed to them can acknowledge the same source.

Top module: `lvlIntc`

## Requirements
- R1: After reset every enable is clear, every mask bit is set and every routing word is zero. As a result, with no doorbell present, every irqOut bit is low and every acknowledge read returns 1023.
- R2: Writing a source number n in busWdata[9:0] to address 0x030 sets the enable of source n. Writing it to 0x034 clears that enable. A write with n = 0 or n >= NUM_SRCS changes nothing.
- R3: The window of CPU c starts at 0x2000 + 0x100*c. Writing n to window offset 0x48 masks source n for that CPU, and writing n to offset 0x4C unmasks it. n = 0, n >= NUM_SRCS and windows for CPU numbers >= NUM_CPUS are ignored.
- R4: The routing word of source n is at 0x100 + 4*n. Bit c of the word lets CPU c see source n. Only bits [NUM_CPUS-1:0] are stored, and reads return zero above them.
- R5: A read of address 0x000 returns NUM_SRCS in bits [11:2] and zero elsewhere.
- R6: A read of window offset 0x44 returns, in bits [9:0], the lowest-numbered source that qualifies for that CPU. A source qualifies when its line is high, its enable is set, its routing bit for the CPU is set and the CPU's mask bit for it is clear. If nothing qualifies, the read returns 1023. The read changes no state.
- R7: When the doorbell input of a CPU is high, that CPU's acknowledge returns 0 and its irqOut is high, regardless of masks. Mask writes of 0 have no effect on this.
- R8: Source TIMER_ID (5) qualifies for CPU c only from cpuTimer[c] and the mask bit of CPU c. srcLevel[TIMER_ID], the enable of TIMER_ID and the routing word of TIMER_ID have no effect.
- R9: irqOut[c] is high exactly when the doorbell of CPU c is high or some source qualifies for CPU c. It follows the levels combinationally, and register writes take effect from the next clock edge.
- R10: busRdata changes only on the clock edge that samples busRead, and is valid from that edge. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| doorbell | input | NUM_CPUS | Inter-processor doorbell summary per CPU |
| cpuTimer | input | NUM_CPUS | Private timer level per CPU |
| srcLevel | input | NUM_SRCS | Shared peripheral levels; bits 0 and TIMER_ID unused |
| irqOut | output | NUM_CPUS | Interrupt request per CPU |

## Verification
A wrong enable, mask or routing bit does not stay hidden. The irqOut bit of the affected CPU is wrong on the first cycle in which that source's line is high, and an acknowledge read issued then returns the wrong number on the next cycle. A fault in the priority choice shows only when two or more sources qualify at once. The stimulus therefore keeps several lines high together, using both low and high source numbers, and compares every CPU's output with a behavioural model on every cycle.

// File: rtl/lvlIntcPkg.sv
package lvlIntcPkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  typedef enum logic [2:0] {
    OP_NONE, OP_EN_SET, OP_EN_CLR, OP_MASK_SET, OP_MASK_CLR, OP_ROUTE_WR
  } wrOp_e;

  typedef enum logic [1:0] {RD_ZERO, RD_CTRL, RD_ROUTE, RD_ACK} rdSel_e;

  typedef struct packed {
    wrOp_e           op;
    logic            rdStb;
    rdSel_e          rd;
    logic [ID_W-1:0] idx;
    logic [3:0]      cpu;
  } strobes_t;
endpackage

// File: rtl/lvlIntcCtrl.sv
module lvlIntcCtrl import lvlIntcPkg::*; #(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRCS = 32,
  parameter int ADDR_W   = 14
) (
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output strobes_t          st
);
  localparam logic [ID_W-1:0] SRC_CNT = ID_W'(NUM_SRCS);
  localparam logic [6:0]      SRC_CNT7 = 7'(NUM_SRCS);
  localparam logic [4:0]      CPU_CNT5 = 5'(NUM_CPUS);
  localparam int              HI_W = ADDR_W - 12;

  logic            aligned, globalWin, cpuWin, cpuOk, routeHit, idxOk;
  logic [11:0]     gOff;
  logic [7:0]      cOff;
  logic [ID_W-1:0] wrIdx;
  logic            unusedWdata;

  assign aligned   = (busAddr[1:0] == 2'b00);
  assign globalWin = (busAddr[ADDR_W-1:12] == HI_W'(0)) && aligned;
  assign cpuWin    = (busAddr[ADDR_W-1:12] == HI_W'(2)) && aligned;
  assign cpuOk     = ({1'b0, busAddr[11:8]} < CPU_CNT5);
  assign gOff      = busAddr[11:0];
  assign cOff      = busAddr[7:0];
  assign routeHit  = globalWin && (busAddr[11:8] == 4'h1) &&
                     ({1'b0, busAddr[7:2]} < SRC_CNT7);
  assign wrIdx     = busWdata[ID_W-1:0];
  assign idxOk     = (wrIdx != '0) && (wrIdx < SRC_CNT);
  assign unusedWdata = ^busWdata[31:ID_W];

  always_comb begin
    st       = '0;
    st.op    = OP_NONE;
    st.rd    = RD_ZERO;
    st.cpu   = busAddr[11:8];
    st.idx   = wrIdx;
    if (busWrite) begin
      if (globalWin && gOff == 12'h030 && idxOk)       st.op = OP_EN_SET;
      else if (globalWin && gOff == 12'h034 && idxOk)  st.op = OP_EN_CLR;
      else if (routeHit) begin
        st.op  = OP_ROUTE_WR;
        st.idx = {4'b0, busAddr[7:2]};
      end
      else if (cpuWin && cpuOk && cOff == 8'h48 && idxOk) st.op = OP_MASK_SET;
      else if (cpuWin && cpuOk && cOff == 8'h4C && idxOk) st.op = OP_MASK_CLR;
    end else if (busRead) begin
      st.rdStb = 1'b1;
      if (globalWin && gOff == 12'h000) st.rd = RD_CTRL;
      else if (routeHit) begin
        st.rd  = RD_ROUTE;
        st.idx = {4'b0, busAddr[7:2]};
      end
      else if (cpuWin && cpuOk && cOff == 8'h44) st.rd = RD_ACK;
    end
  end
endmodule

// File: rtl/lvlIntcData.sv
module lvlIntcData import lvlIntcPkg::*; #(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRCS = 32,
  parameter int TIMER_ID = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobes_t                 st,
  input  logic [NUM_CPUS-1:0]      routeData,
  input  logic [NUM_CPUS-1:0]      doorbell,
  input  logic [NUM_CPUS-1:0]      cpuTimer,
  input  logic [NUM_SRCS-1:0]      srcLevel,
  output logic [NUM_CPUS-1:0]      irqOut,
  output logic [NUM_CPUS*ID_W-1:0] ackFlat,
  output logic [31:0]              busRdata
);
  localparam int SRC_W = $clog2(NUM_SRCS);
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  logic [NUM_SRCS-1:0] enReg;
  logic [NUM_SRCS-1:0] maskReg  [NUM_CPUS];
  logic [NUM_CPUS-1:0] routeReg [NUM_SRCS];
  logic [SRC_W-1:0]    sIdx;
  logic [CPU_W-1:0]    cSel;
  logic [NUM_CPUS-1:0] unusedMask0;
  logic                unusedBits;

  assign sIdx = st.idx[SRC_W-1:0];
  assign cSel = st.cpu[CPU_W-1:0];
  assign unusedBits = ^{st.idx[ID_W-1:SRC_W], st.cpu, srcLevel[0], srcLevel[TIMER_ID],
                        enReg[0], enReg[TIMER_ID], unusedMask0};

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg <= '0;
      for (int c = 0; c < NUM_CPUS; c++) maskReg[c] <= '1;
      for (int n = 0; n < NUM_SRCS; n++) routeReg[n] <= '0;
    end else begin
      case (st.op)
        OP_EN_SET:   enReg[sIdx] <= 1'b1;
        OP_EN_CLR:   enReg[sIdx] <= 1'b0;
        OP_MASK_SET: maskReg[cSel][sIdx] <= 1'b1;
        OP_MASK_CLR: maskReg[cSel][sIdx] <= 1'b0;
        OP_ROUTE_WR: routeReg[sIdx] <= routeData;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRCS-1:0] qual;
    logic [ID_W-1:0]     pick;

    always_comb begin
      qual = '0;
      for (int n = 1; n < NUM_SRCS; n++) begin
        if (n == TIMER_ID) qual[n] = cpuTimer[c] & ~maskReg[c][n];
        else qual[n] = srcLevel[n] & enReg[n] & routeReg[n][c] & ~maskReg[c][n];
      end
    end

    always_comb begin
      pick = NONE_ID;
      for (int n = NUM_SRCS - 1; n >= 1; n--) begin
        if (qual[n]) pick = ID_W'(n);
      end
      if (doorbell[c]) pick = '0;
    end

    assign irqOut[c] = doorbell[c] | (|qual);
    assign ackFlat[c*ID_W +: ID_W] = pick;
    assign unusedMask0[c] = maskReg[c][0];
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else if (st.rdStb) begin
      case (st.rd)
        RD_CTRL:  busRdata <= 32'(NUM_SRCS) << 2;
        RD_ROUTE: busRdata <= 32'(routeReg[sIdx]);
        RD_ACK:   busRdata <= 32'(ackFlat[cSel*ID_W +: ID_W]);
        default:  busRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lvlIntc.sv
module lvlIntc import lvlIntcPkg::*; #(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRCS = 32,
  parameter int TIMER_ID = 5,
  parameter int ADDR_W   = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_CPUS-1:0] doorbell,
  input  logic [NUM_CPUS-1:0] cpuTimer,
  input  logic [NUM_SRCS-1:0] srcLevel,
  output logic [NUM_CPUS-1:0] irqOut
);
  strobes_t                 st;
  logic [NUM_CPUS*ID_W-1:0] ackFlat;

  lvlIntcCtrl #(.NUM_CPUS(NUM_CPUS), .NUM_SRCS(NUM_SRCS), .ADDR_W(ADDR_W)) uCtrl (
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busWdata(busWdata), .st(st)
  );

  lvlIntcData #(.NUM_CPUS(NUM_CPUS), .NUM_SRCS(NUM_SRCS), .TIMER_ID(TIMER_ID)) uData (
    .clk(clk), .rst(rst), .st(st), .routeData(busWdata[NUM_CPUS-1:0]),
    .doorbell(doorbell), .cpuTimer(cpuTimer), .srcLevel(srcLevel),
    .irqOut(irqOut), .ackFlat(ackFlat), .busRdata(busRdata)
  );
endmodule

// File: rtl/lvlIntcChk.sv
module lvlIntcChk #(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRCS = 32,
  parameter int ADDR_W   = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   busRead,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [31:0]            busRdata,
  input logic [NUM_CPUS-1:0]    doorbell,
  input logic [NUM_CPUS-1:0]    irqOut,
  input logic [NUM_CPUS*10-1:0] ackFlat
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
    p_doorbell_first_r7: assert property (@(posedge clk) disable iff (rst)
      doorbell[c] |-> (ackFlat[c*10 +: 10] == 10'd0) && irqOut[c]);
    p_irq_vs_ack_r9: assert property (@(posedge clk) disable iff (rst)
      irqOut[c] == (ackFlat[c*10 +: 10] != 10'd1023));
    p_ack_legal_r6: assert property (@(posedge clk) disable iff (rst)
      (32'(ackFlat[c*10 +: 10]) < NUM_SRCS) || (ackFlat[c*10 +: 10] == 10'd1023));
  end

  p_ctrl_value_r5: assert property (@(posedge clk) disable iff (rst)
    busRead && (busAddr == '0) |=> busRdata == (32'(NUM_SRCS) << 2));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !busRead |=> $stable(busRdata));
endmodule

bind lvlIntc lvlIntcChk #(.NUM_CPUS(NUM_CPUS), .NUM_SRCS(NUM_SRCS), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst(rst), .busRead(busRead), .busAddr(busAddr), .busRdata(busRdata),
  .doorbell(doorbell), .irqOut(irqOut), .ackFlat(ackFlat)
);

// File: tb/lvlIntc_test.sv
module lvlIntc_test;
  localparam int NC = 2;
  localparam int NS = 32;
  localparam int TM = 5;

  logic        clk = 0;
  logic        rst = 1;
  logic        busWrite = 0, busRead = 0;
  logic [13:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [NC-1:0] doorbell = 0, cpuTimer = 0, irqOut;
  logic [NS-1:0] srcLevel = 0;

  int checks = 0, fails = 0;
  bit running = 0;

  bit        mEn [NS];
  bit        mMask [NC][NS];
  bit [1:0]  mRoute [NS];
  logic [31:0] mRd;

  lvlIntc uut (.clk(clk), .rst(rst), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .doorbell(doorbell), .cpuTimer(cpuTimer), .srcLevel(srcLevel), .irqOut(irqOut));

  always #2.5 clk = ~clk;

  function automatic bit qualifies(int c, int n);
    if (n == TM) return cpuTimer[c] && !mMask[c][n];
    return srcLevel[n] && mEn[n] && mRoute[n][c] && !mMask[c][n];
  endfunction

  function automatic int expAck(int c);
    if (doorbell[c]) return 0;
    for (int n = 1; n < NS; n++) if (qualifies(c, n)) return n;
    return 1023;
  endfunction

  function automatic logic [31:0] expRead(logic [13:0] a);
    if (a == 14'h000) return 32'(NS * 4);
    if (a >= 14'h100 && a < 14'h100 + 14'(NS * 4) && a[1:0] == 0) return 32'(mRoute[(a - 14'h100) / 4]);
    for (int c = 0; c < NC; c++) if (a == 14'h2044 + 14'(c * 256)) return 32'(expAck(c));
    return 0;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NS; n++) begin
        mEn[n] = 0; mRoute[n] = 0;
        for (int c = 0; c < NC; c++) mMask[c][n] = 1;
      end
      mRd = 0;
    end else if (busWrite) begin
      int v;
      v = int'(busWdata[9:0]);
      if (v >= 1 && v < NS) begin
        if (busAddr == 14'h030) mEn[v] = 1;
        if (busAddr == 14'h034) mEn[v] = 0;
        for (int c = 0; c < NC; c++) begin
          if (busAddr == 14'h2048 + 14'(c * 256)) mMask[c][v] = 1;
          if (busAddr == 14'h204C + 14'(c * 256)) mMask[c][v] = 0;
        end
      end
      if (busAddr >= 14'h100 && busAddr < 14'h100 + 14'(NS * 4) && busAddr[1:0] == 0)
        mRoute[(busAddr - 14'h100) / 4] = busWdata[1:0];
    end else if (busRead) begin
      mRd = expRead(busAddr);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (running && !rst) begin
      for (int c = 0; c < NC; c++) begin
        logic e;
        e = doorbell[c] || (expAck(c) != 1023);
        check("R9 irqOut vs model", 32'(irqOut[c]), 32'(e));
      end
      check("R10 busRdata vs model", busRdata, mRd);
    end
  end

  task automatic wr(logic [13:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1;
    @(negedge clk);
    busWrite = 0;
  endtask

  task automatic rdChk(logic [13:0] a, logic [31:0] exp, string tag);
    busAddr = a; busRead = 1;
    @(negedge clk);
    busRead = 0;
    #1;
    check(tag, busRdata, exp);
    @(negedge clk);
  endtask

  task automatic irqChk(int c, logic exp, string tag);
    #1;
    check(tag, 32'(irqOut[c]), 32'(exp));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; running = 1;
    @(negedge clk);
    // R1 reset state
    srcLevel = '1;
    irqChk(0, 0, "R1 irq0 after reset");
    irqChk(1, 0, "R1 irq1 after reset");
    rdChk(14'h2044, 1023, "R1 ack cpu0 after reset");
    rdChk(14'h10C, 0, "R1 route after reset");
    srcLevel = 0;
    // R5 control word
    rdChk(14'h000, 32'(NS) << 2, "R5 source count");
    // R2 enable set/clear
    srcLevel[7] = 1;
    wr(14'h11C, 1);
    wr(14'h204C, 7);
    irqChk(0, 0, "R2 disabled source silent");
    wr(14'h030, 7);
    irqChk(0, 1, "R2 enabled source raises irq0");
    rdChk(14'h2044, 7, "R6 ack cpu0 single source");
    irqChk(1, 0, "R4 unrouted cpu1 quiet");
    wr(14'h034, 7);
    irqChk(0, 0, "R2 enable cleared");
    wr(14'h030, 0);
    wr(14'h030, 40);
    rdChk(14'h2044, 1023, "R2 out-of-range set ignored");
    // R3 mask
    wr(14'h030, 7);
    wr(14'h2048, 7);
    irqChk(0, 0, "R3 masked source");
    wr(14'h234C, 7);
    irqChk(0, 0, "R3 absent cpu window ignored");
    wr(14'h204C, 7);
    irqChk(0, 1, "R3 unmasked again");
    // R6 priority and shared acknowledge
    srcLevel[3] = 1;
    wr(14'h10C, 3);
    wr(14'h030, 3);
    wr(14'h204C, 3);
    wr(14'h214C, 3);
    rdChk(14'h2044, 3, "R6 lowest id wins cpu0");
    rdChk(14'h2144, 3, "R6 cpu1 acks same source");
    rdChk(14'h2044, 3, "R6 ack read has no side effect");
    srcLevel[3] = 0;
    rdChk(14'h2044, 7, "R9 level drop falls back");
    rdChk(14'h2144, 1023, "R9 cpu1 nothing left");
    // R4 routing word
    rdChk(14'h10C, 3, "R4 route readback");
    wr(14'h124, 32'hFFFF_FFFF);
    rdChk(14'h124, 3, "R4 only cpu bits stored");
    // R8 private timer
    cpuTimer[1] = 1;
    irqChk(1, 0, "R8 timer masked by default");
    wr(14'h214C, TM);
    rdChk(14'h2144, TM, "R8 timer unmasked cpu1");
    rdChk(14'h2044, 7, "R8 cpu0 unaffected by cpu1 timer");
    wr(14'h034, TM);
    rdChk(14'h2144, TM, "R8 enable has no effect on timer");
    srcLevel[TM] = 1;
    wr(14'h030, TM);
    wr(14'h114, 1);
    wr(14'h204C, TM);
    rdChk(14'h2044, 7, "R8 shared line ignored for timer");
    cpuTimer[0] = 1;
    rdChk(14'h2044, TM, "R8 own timer seen by cpu0");
    cpuTimer = 0;
    // R7 doorbell
    doorbell = 2'b11;
    rdChk(14'h2044, 0, "R7 doorbell id cpu0");
    rdChk(14'h2144, 0, "R7 doorbell id cpu1");
    wr(14'h2048, 0);
    rdChk(14'h2044, 0, "R7 mask write of zero ignored");
    doorbell = 0;
    rdChk(14'h2044, 7, "R7 doorbell released");
    // R10 unmapped reads
    rdChk(14'h0040, 0, "R10 unmapped global read");
    rdChk(14'h2344, 0, "R10 absent cpu window read");
    // mixed traffic, compared on every cycle
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      srcLevel = $urandom;
      if ($urandom_range(0, 3) == 0) cpuTimer = NC'($urandom);
      if ($urandom_range(0, 7) == 0) doorbell = NC'($urandom);
      case (k)
        0: wr(14'h030, $urandom_range(0, NS + 2));
        1: wr(14'h034, $urandom_range(0, NS + 2));
        2: wr(14'h100 + 14'(4 * $urandom_range(0, NS - 1)), $urandom);
        3: wr(14'h2048 + 14'(256 * $urandom_range(0, NC - 1)), $urandom_range(0, NS));
        4: wr(14'h204C + 14'(256 * $urandom_range(0, NC - 1)), $urandom_range(0, NS));
        5, 6: begin
          busAddr = 14'h2044 + 14'(256 * $urandom_range(0, NC - 1)); busRead = 1;
          @(negedge clk); busRead = 0;
        end
        7: begin
          busAddr = 14'h100 + 14'(4 * $urandom_range(0, NS - 1)); busRead = 1;
          @(negedge clk); busRead = 0;
        end
        default: @(negedge clk);
      endcase
    end
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule